// File: doc/BRIEF.md
# Shared-Tree Byte Parity Checker and Generator

This block sits on one side of a bidirectional data port whose words are made of four parity-protected 9-bit lanes. It checks every word on the incoming bus against the selected parity type and reports a failing lane on an active-low error flag. It also computes fresh parity bits for words that leave the port on a read, when parity generation is turned on. One input picks odd or even parity for checking and for generation alike.

The lane parity tree that checks the incoming bus is the same tree that builds parity for the mail-register word read out on this port. When a mail read with generation is set up, that tree is taken away from the bus, so the error flag is held in the pass state whatever the bus carries. Reads from the ordinary storage path use a separate generator and never borrow the check tree.

A small mode decoder names how the tree is being used: `TREE_CHECK_BUS` (write, or read with generation off: the tree checks the bus and read data passes unchanged), `TREE_GEN_STORE` (storage read with generation: the tree checks the bus, and the store generator rewrites the read word) and `TREE_GEN_MAIL` (mail read with generation: the tree is lent to the mail word and the flag is forced to pass). The mode changes combinationally on each input change. Any input pattern that is not a generating read leads to `TREE_CHECK_BUS`. A generating read leads to `TREE_GEN_MAIL` when the mailbox select is high and to `TREE_GEN_STORE` when it is low. A registered copy of the flag is updated on every rising clock edge.

Top module: `bpar_port`

## Requirements
- R1: A word is split into four lanes at bits 8:0, 17:9, 26:18 and 35:27. Bit 8, 17, 26 or 35, the top bit of each lane, is that lane's parity bit, and the eight bits below it are its data.
- R2: With `odd_sel` = 1 a lane passes when its nine bits hold an odd number of ones. With `odd_sel` = 0 it passes when they hold an even number. This select also sets the type of generated parity.
- R3: With the tree checking the bus, `perr_n` is 0 in the same cycle that any lane of `bus_in` fails, and 1 when all four lanes pass.
- R4: With `port_wr` = 0, `mbox_sel` = 1 and `gen_en` = 1, `perr_n` is 1 whatever `bus_in` carries.
- R5: On a read with generation (`port_wr` = 0, `gen_en` = 1), each lane of `rd_data_out` carries the eight data bits of `rd_data_in` unchanged. Its top bit is the selected parity computed over those eight bits only.
- R6: On a write (`port_wr` = 1), or with `gen_en` = 0, `rd_data_out` equals `rd_data_in` bit for bit, stored parity bits included.
- R7: `perr_n_q` takes the value of `perr_n` at each rising edge of `clk`. It reads 1 while `rst_n` is low.
- R8: The flag is forced only when all three conditions of R4 hold. A write with `mbox_sel` and `gen_en` high, or a storage read with generation (`mbox_sel` = 0), still checks `bus_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock for the registered flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| port_wr | input | 1 | 1 selects a write, 0 selects a read on the port |
| mbox_sel | input | 1 | 1 routes the read through the mail register |
| gen_en | input | 1 | 1 enables parity generation on reads |
| bus_in | input | 36 | Word arriving on the port bus, checked lane by lane |
| rd_data_in | input | 36 | Word to be read out (storage or mail register) |
| rd_data_out | output | 36 | Read word, with generated parity bits when enabled |
| perr_n | output | 1 | Combinational active-low lane parity error |
| perr_n_q | output | 1 | Registered copy of `perr_n` |

## Verification
The bench builds the block with its default shape of four 9-bit lanes, the only shape the port width allows, so every lane boundary and every parity bit position is visible at the ports. Directed patterns place a single error in each lane in turn under both parity types. They cover all eight combinations of the three mode inputs with a corrupt bus, which sets the forced-pass case against each near miss. A long run of random words and mode inputs is then compared on every clock against a counting model of the lanes.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    // How the shared lane tree is being used in the current cycle
    typedef enum logic [1:0] {
        TREE_CHECK_BUS = 2'd0,
        TREE_GEN_STORE = 2'd1,
        TREE_GEN_MAIL  = 2'd2
    } tree_use_e;

endpackage

// File: rtl/bpar_lane_tree.sv
module bpar_lane_tree #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic              odd_sel,
    output logic [LANES-1:0]  lane_bad,
    output logic [LANES-1:0]  lane_gen
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] data_bits;
        logic              par_bit;
        logic              data_xor;

        assign data_bits   = word[g*LANE_W +: DATA_W];
        assign par_bit     = word[g*LANE_W + DATA_W];
        assign data_xor    = ^data_bits;
        // parity bit that makes the lane meet the selected type
        assign lane_gen[g] = data_xor ^ odd_sel;
        // lane fails when its full xor differs from the selected type
        assign lane_bad[g] = (data_xor ^ par_bit) != odd_sel;
    end

endmodule

// File: rtl/bpar_ctrl.sv
module bpar_ctrl
    import bpar_pkg::*;
(
    input  logic      port_wr,
    input  logic      mbox_sel,
    input  logic      gen_en,
    output tree_use_e tree_use
);

    always_comb begin
        if (port_wr || !gen_en) begin
            tree_use = TREE_CHECK_BUS;
        end else if (mbox_sel) begin
            tree_use = TREE_GEN_MAIL;
        end else begin
            tree_use = TREE_GEN_STORE;
        end
    end

endmodule

// File: rtl/bpar_port.sv
module bpar_port
    import bpar_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_sel,
    input  logic              port_wr,
    input  logic              mbox_sel,
    input  logic              gen_en,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] rd_data_in,
    output logic [WORD_W-1:0] rd_data_out,
    output logic              perr_n,
    output logic              perr_n_q
);

    tree_use_e         tree_use;
    logic [WORD_W-1:0] tree_src;
    logic [LANES-1:0]  shared_bad;
    logic [LANES-1:0]  shared_gen;
    logic [LANES-1:0]  store_gen;
    logic [LANES-1:0]  gen_bits;
    logic              gen_on;
    logic              perr_comb;

    bpar_ctrl u_ctrl (
        .port_wr  (port_wr),
        .mbox_sel (mbox_sel),
        .gen_en   (gen_en),
        .tree_use (tree_use)
    );

    // the shared tree is lent to the mail word during a generating mail read
    assign tree_src = (tree_use == TREE_GEN_MAIL) ? rd_data_in : bus_in;

    bpar_lane_tree #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_shared (
        .word     (tree_src),
        .odd_sel  (odd_sel),
        .lane_bad (shared_bad),
        .lane_gen (shared_gen)
    );

    // dedicated generator for storage reads
    for (genvar s = 0; s < LANES; s++) begin : g_store
        assign store_gen[s] = (^rd_data_in[s*LANE_W +: DATA_W]) ^ odd_sel;
    end

    // output process
    always_comb begin
        unique case (tree_use)
            TREE_CHECK_BUS: begin
                perr_comb = ~|shared_bad;
                gen_bits  = store_gen;
                gen_on    = 1'b0;
            end
            TREE_GEN_STORE: begin
                perr_comb = ~|shared_bad;
                gen_bits  = store_gen;
                gen_on    = 1'b1;
            end
            TREE_GEN_MAIL: begin
                perr_comb = 1'b1;
                gen_bits  = shared_gen;
                gen_on    = 1'b1;
            end
            default: begin
                perr_comb = ~|shared_bad;
                gen_bits  = store_gen;
                gen_on    = 1'b0;
            end
        endcase
    end

    for (genvar o = 0; o < LANES; o++) begin : g_out
        assign rd_data_out[o*LANE_W +: DATA_W] = rd_data_in[o*LANE_W +: DATA_W];
        assign rd_data_out[o*LANE_W + DATA_W]  =
            gen_on ? gen_bits[o] : rd_data_in[o*LANE_W + DATA_W];
    end

    assign perr_n = perr_comb;

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perr_n_q <= 1'b1;
        end else begin
            perr_n_q <= perr_comb;
        end
    end

endmodule

// File: rtl/bpar_port_chk.sv
module bpar_port_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              odd_sel,
    input logic              port_wr,
    input logic              mbox_sel,
    input logic              gen_en,
    input logic [WORD_W-1:0] rd_data_in,
    input logic [WORD_W-1:0] rd_data_out,
    input logic              perr_n,
    input logic              perr_n_q
);

    logic [LANES-1:0] out_lane_ok;
    logic [LANES-1:0] data_same;

    for (genvar c = 0; c < LANES; c++) begin : g_chk
        assign out_lane_ok[c] = (^rd_data_out[c*LANE_W +: LANE_W]) == odd_sel;
        assign data_same[c]   =
            rd_data_out[c*LANE_W +: DATA_W] == rd_data_in[c*LANE_W +: DATA_W];
    end

    AST_MAIL_GEN_FORCES_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_wr && mbox_sel && gen_en) |-> perr_n); // R4

    AST_GEN_LANES_MEET_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_wr && gen_en) |-> (&out_lane_ok)); // R5

    AST_DATA_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (&data_same)); // R5

    AST_NO_GEN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr || !gen_en) |-> (rd_data_out == rd_data_in)); // R6

    AST_FLAG_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (perr_n_q == $past(perr_n))); // R7

endmodule

bind bpar_port bpar_port_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .odd_sel     (odd_sel),
    .port_wr     (port_wr),
    .mbox_sel    (mbox_sel),
    .gen_en      (gen_en),
    .rd_data_in  (rd_data_in),
    .rd_data_out (rd_data_out),
    .perr_n      (perr_n),
    .perr_n_q    (perr_n_q)
);

// File: tb/sim_bpar_port.sv
`timescale 1ns/1ps
module sim_bpar_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        odd_sel = 1'b0;
    logic        port_wr = 1'b1;
    logic        mbox_sel = 1'b0;
    logic        gen_en = 1'b0;
    logic [35:0] bus_in = '0;
    logic [35:0] rd_data_in = '0;
    logic [35:0] rd_data_out;
    logic        perr_n;
    logic        perr_n_q;

    int checks = 0;
    int fails = 0;
    logic exp_flag_q = 1'b1;

    always #10 clk = ~clk;

    bpar_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .odd_sel     (odd_sel),
        .port_wr     (port_wr),
        .mbox_sel    (mbox_sel),
        .gen_en      (gen_en),
        .bus_in      (bus_in),
        .rd_data_in  (rd_data_in),
        .rd_data_out (rd_data_out),
        .perr_n      (perr_n),
        .perr_n_q    (perr_n_q)
    );

    // ---------------- behavioural reference ----------------
    function automatic int ones_in(input logic [35:0] w, input int lo, input int n);
        int cnt = 0;
        for (int b = lo; b < lo + n; b++) if (w[b]) cnt++;
        return cnt;
    endfunction

    function automatic logic ref_flag(input logic [35:0] bus, input logic odd,
                                      input logic wr, input logic mb, input logic ge);
        logic ok = 1'b1;
        if (!wr && mb && ge) return 1'b1;
        for (int l = 0; l < 4; l++) begin
            if ((ones_in(bus, l * 9, 9) % 2) != (odd ? 1 : 0)) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [35:0] ref_out(input logic [35:0] rd, input logic odd,
                                            input logic wr, input logic ge);
        logic [35:0] r = rd;
        if (!wr && ge) begin
            for (int l = 0; l < 4; l++) begin
                // parity bit chosen so the nine bits meet the selected type
                r[l*9 + 8] = ((ones_in(rd, l * 9, 8) % 2) == 1) ^ odd;
            end
        end
        return r;
    endfunction

    task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // mirror of the flag register, updated on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_flag_q <= 1'b1;
        else        exp_flag_q <= ref_flag(bus_in, odd_sel, port_wr, mbox_sel, gen_en);
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check1("R3/R4/R8 perr_n", {63'd0, perr_n},
                   {63'd0, ref_flag(bus_in, odd_sel, port_wr, mbox_sel, gen_en)});
            check1("R5/R6 rd_data_out", {28'd0, rd_data_out},
                   {28'd0, ref_out(rd_data_in, odd_sel, port_wr, gen_en)});
            check1("R7 perr_n_q", {63'd0, perr_n_q}, {63'd0, exp_flag_q});
        end
    end

    // build a word whose lanes all pass the given type
    function automatic logic [35:0] good_word(input logic [35:0] seed, input logic odd);
        logic [35:0] w = seed;
        for (int l = 0; l < 4; l++)
            w[l*9 + 8] = ((ones_in(seed, l * 9, 8) % 2) == 1) ^ odd;
        return w;
    endfunction

    task automatic apply(input logic odd, input logic wr, input logic mb, input logic ge,
                         input logic [35:0] bus, input logic [35:0] rd);
        @(posedge clk);
        #2;
        odd_sel = odd; port_wr = wr; mbox_sel = mb; gen_en = ge;
        bus_in = bus; rd_data_in = rd;
    endtask

    initial begin : watchdog
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [35:0] g;
        // reset state
        bus_in = 36'h0_0000_0001;
        #25;
        check1("R7 reset perr_n_q", {63'd0, perr_n_q}, 64'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2/R3: clean words under each type
        for (int t = 0; t < 2; t++) begin
            g = good_word(36'h3_5A5A_C3C3, t[0]);
            apply(t[0], 1'b1, 1'b0, 1'b0, g, 36'h0);
            // R1: flip each lane's parity bit, then one data bit, alone
            for (int l = 0; l < 4; l++) begin
                apply(t[0], 1'b1, 1'b0, 1'b0, g ^ (36'd1 << (l*9 + 8)), 36'h0);
                apply(t[0], 1'b1, 1'b0, 1'b0, g ^ (36'd1 << (l*9 + 3)), 36'h0);
            end
            // wrong type on a word built for the other
            apply(~t[0], 1'b1, 1'b0, 1'b0, g, 36'h0);
        end

        // R4/R8: all mode combinations on a corrupt bus
        for (int m = 0; m < 8; m++) begin
            apply(1'b1, m[2], m[1], m[0], 36'h0_0000_0000, 36'h9_1234_5678);
            apply(1'b0, m[2], m[1], m[0], 36'h0_0000_0100, 36'hF_FFFF_FFFF);
        end

        // R5/R6: generation and pass-through on fixed read words
        apply(1'b1, 1'b0, 1'b1, 1'b1, 36'h0, 36'hA_BCDE_F012);
        apply(1'b0, 1'b0, 1'b0, 1'b1, 36'h0, 36'hA_BCDE_F012);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 36'h0, 36'hA_BCDE_F012);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 36'h0, 36'hA_BCDE_F012);

        // random run
        for (int i = 0; i < 2000; i++) begin
            logic [35:0] rb;
            logic [35:0] rr;
            logic [3:0]  k;
            rb = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            rr = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            k  = 4'($urandom);
            if (k[3]) rb = good_word(rb, k[0]);
            apply(k[0], k[1], k[2], k[3] | k[1], rb, rr);
        end

        // reset again mid-run: R7 reset value
        @(negedge clk);
        bus_in = 36'h0_0000_0001; port_wr = 1'b1;
        rst_n = 1'b0;
        #3;
        check1("R7 reset perr_n_q", {63'd0, perr_n_q}, 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule